// File: doc/BRIEF.md
# Pin-Change Interrupt Detector for a Two-Port I/O Expander

This block produces the input-change interrupt of a 16-pin, two-port general-purpose I/O expander. It holds one snapshot register per 8-bit port. The interrupt is the OR of every bit where a synchronized live pin differs from its snapshot, counting only pins whose direction bit selects input. The interrupt is not a sticky flag. It is recomputed every cycle. A pin that moves away and then comes back before any read releases the line without host action. A pin that moves after a read has sampled it raises the line again.

A host uses a small synchronous register port. A read strobe copies the synchronized pins of the addressed port into that port's snapshot and returns the copied byte one cycle later. A read that opens a transaction at port 0 steps to port 1 on the next data strobe. Direction registers are written and read through the same address space. The interrupt output is the enable of an open-drain pull-down. A high level means the line is pulled low, and an external resistor raises the line when the enable is low.

Top module: `gpio_chg_irq`

## Requirements
- R1: During reset and for a short priming phase after it, irq_pd_o is 0. Both direction registers reset to 8'hFF, where 1 means input and 0 means output. rd_data_o resets to 0. Each snapshot is loaded with the synchronized pins during priming, so irq_pd_o is 0 after priming even when pins are not zero.
- R2: When an input pin changes, irq_pd_o goes to 1 after exactly two rising edges of the synchronizer, counted from the edge at which the pin is first sampled. A value of 1 means the pull-down is active.
- R3: A read strobe (rd_en_i) at address 0 (port 0, pins 7:0) or address 1 (port 1, pins 15:8) copies that port's synchronized pins into its snapshot at that edge. rd_data_o presents the copied byte from the next cycle on. irq_pd_o clears if no other mismatch remains.
- R4: If a pin leaves and then returns to its snapshot value without a read, irq_pd_o returns to 0 by itself.
- R5: A pin change that arrives after the capturing edge of a read is not lost. irq_pd_o rises again two edges later, and the read data keeps the earlier value.
- R6: Direction registers sit at address 2 (port 0) and address 3 (port 1). They are written with wr_en_i and can be read back. A pin whose direction bit is 0 never affects irq_pd_o. A write to any other address changes nothing.
- R7: When rd_start_i opens a transaction at address 0, the next strobe with rd_start_i low reads address 1. In general, the pointer toggles address bit 0 after every strobe.
- R8: A read of one port leaves the other port's snapshot untouched, so that port's pending mismatches keep irq_pd_o at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_i | input | 16 | Live pin levels, port 1 in the upper byte |
| rd_start_i | input | 1 | Opens a transaction: rd_addr_i replaces the internal pointer |
| rd_addr_i | input | 3 | Register address used when rd_start_i is high |
| rd_en_i | input | 1 | Read data strobe for one cycle |
| rd_data_o | output | 8 | Data of the last strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| irq_pd_o | output | 1 | Pull-down enable of the active-low open-drain interrupt |

## Verification
The bench targets the cases where a detector built as a latched flag would go wrong. A pin that toggles and then returns would leave such a design stuck asserted. A change that lands right after the read sample would be lost, or would be reported in the read byte. A read of one port could wipe out the other port's pending change. A design that fails to prime its snapshots, that counts output pins in the interrupt, or that reads port 0 twice instead of stepping to port 1 shows a wrong irq_pd_o or a wrong data byte at a fixed cycle, and the bench compares against that cycle.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef logic [ADDR_W-1:0] reg_addr_t;

  // Snapshot (input port) registers start here, one per port.
  localparam int ADR_IN_BASE  = 0;
  // Direction registers start here, one per port.
  localparam int ADR_DIR_BASE = 2;

  // Auto-increment: stay in the register pair, flip the low address bit.
  function automatic reg_addr_t pair_next(input reg_addr_t a);
    return {a[ADDR_W-1:1], ~a[0]};
  endfunction
endpackage

// File: rtl/chg_pin_sync.sv
module chg_pin_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chg_port_snap.sv
module chg_port_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prime_i,
  input  logic         cap_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] dir_i,
  output logic [W-1:0] snap_o,
  output logic         diff_o
);
  logic [W-1:0] snap_q, snap_d;
  logic         snap_en;

  assign snap_en = prime_i | cap_i;

  always_comb begin
    snap_d = snap_q;
    if (snap_en) snap_d = live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  // Live compare: no memory, a pin returning to its snapshot clears itself.
  assign diff_o = |((live_i ^ snap_q) & dir_i);
  assign snap_o = snap_q;
endmodule

// File: rtl/chg_reg_ctrl.sv
module chg_reg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int W  = 8,
  parameter int NP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_start_i,
  input  reg_addr_t       rd_addr_i,
  input  logic            rd_en_i,
  input  logic            wr_en_i,
  input  reg_addr_t       wr_addr_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic [NP*W-1:0] live_i,
  output logic [NP-1:0]   cap_o,
  output logic [NP*W-1:0] dir_o,
  output reg_addr_t       eff_addr_o,
  output reg_addr_t       ptr_o,
  output logic [W-1:0]    rd_data_o
);
  reg_addr_t    ptr_q, ptr_d, eff_addr;
  logic [W-1:0] rdat_q, rdat_d, rd_mux;
  logic [NP*W-1:0] dir_q;

  assign eff_addr = rd_start_i ? rd_addr_i : ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (rd_en_i)         ptr_d = pair_next(eff_addr);
    else if (rd_start_i) ptr_d = rd_addr_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NP; p++) begin
      if (eff_addr == reg_addr_t'(ADR_IN_BASE + p))  rd_mux = live_i[p*W +: W];
      if (eff_addr == reg_addr_t'(ADR_DIR_BASE + p)) rd_mux = dir_q[p*W +: W];
    end
  end

  always_comb begin
    rdat_d = rdat_q;
    if (rd_en_i) rdat_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      rdat_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      rdat_q <= rdat_d;
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_port
      localparam reg_addr_t IN_A  = reg_addr_t'(ADR_IN_BASE + gp);
      localparam reg_addr_t DIR_A = reg_addr_t'(ADR_DIR_BASE + gp);
      logic         dir_en;
      logic [W-1:0] dir_d;

      assign cap_o[gp] = rd_en_i && (eff_addr == IN_A);
      assign dir_en    = wr_en_i && (wr_addr_i == DIR_A);

      always_comb begin
        dir_d = dir_q[gp*W +: W];
        if (dir_en) dir_d = wr_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q[gp*W +: W] <= '1;
        else        dir_q[gp*W +: W] <= dir_d;
      end
    end
  endgenerate

  assign dir_o      = dir_q;
  assign eff_addr_o = eff_addr;
  assign ptr_o      = ptr_q;
  assign rd_data_o  = rdat_q;
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gpio_chg_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*PORT_W-1:0]   pins_i,
  input  logic                  rd_start_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic                  rd_en_i,
  output logic [PORT_W-1:0]     rd_data_o,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [PORT_W-1:0]     wr_data_i,
  output logic                  irq_pd_o
);
  localparam int NP       = 2;
  localparam int PINS     = NP * PORT_W;
  localparam int PRIME_N  = SYNC_STAGES + 1;
  localparam int PRIME_W  = $clog2(PRIME_N + 1);

  // Reset: asserted at once, released after two edges.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Priming phase: snapshots follow the synchronized pins.
  logic [PRIME_W-1:0] prime_q, prime_d;
  logic               priming;
  assign priming = (prime_q != '0);
  always_comb begin
    prime_d = prime_q;
    if (priming) prime_d = prime_q - PRIME_W'(1);
  end
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) prime_q <= PRIME_W'(PRIME_N);
    else             prime_q <= prime_d;
  end

  logic [PINS-1:0] pins_sync;
  chg_pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_i),
    .rst_n (rst_sync_n),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  logic [NP-1:0]   cap;
  logic [PINS-1:0] dir_all;
  reg_addr_t       eff_addr, ptr;

  chg_reg_ctrl #(.W(PORT_W), .NP(NP)) u_regs (
    .clk        (clk_i),
    .rst_n      (rst_sync_n),
    .rd_start_i (rd_start_i),
    .rd_addr_i  (rd_addr_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .live_i     (pins_sync),
    .cap_o      (cap),
    .dir_o      (dir_all),
    .eff_addr_o (eff_addr),
    .ptr_o      (ptr),
    .rd_data_o  (rd_data_o)
  );

  logic [NP-1:0]   port_diff;
  logic [PINS-1:0] snap_all;

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_snap
      chg_port_snap #(.W(PORT_W)) u_snap (
        .clk     (clk_i),
        .rst_n   (rst_sync_n),
        .prime_i (priming),
        .cap_i   (cap[gp]),
        .live_i  (pins_sync[gp*PORT_W +: PORT_W]),
        .dir_i   (dir_all[gp*PORT_W +: PORT_W]),
        .snap_o  (snap_all[gp*PORT_W +: PORT_W]),
        .diff_o  (port_diff[gp])
      );
    end
  endgenerate

  assign irq_pd_o = !priming && (|port_diff);
endmodule

// File: rtl/chg_irq_checker.sv
module chg_irq_checker
  import gpio_chg_pkg::*;
#(
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          priming,
  input logic          rd_en,
  input reg_addr_t     eff_addr,
  input reg_addr_t     ptr,
  input logic [2*W-1:0] sync,
  input logic [2*W-1:0] snap,
  input logic [2*W-1:0] dir,
  input logic [W-1:0]  rd_data,
  input logic          irq
);
  p_quiet_priming_r1: assert property (@(posedge clk) disable iff (!rst_n)
    priming |-> !irq);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && eff_addr == reg_addr_t'(ADR_IN_BASE) && !priming)
    |=> snap[W-1:0] == $past(sync[W-1:0]));

  p_rdata_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && eff_addr == reg_addr_t'(ADR_IN_BASE + 1) && !priming)
    |=> rd_data == snap[2*W-1:W]);

  p_outputs_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == '0) |-> !irq);

  p_autoinc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && eff_addr == reg_addr_t'(ADR_IN_BASE)) |=> ptr == reg_addr_t'(ADR_IN_BASE + 1));

  p_other_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!priming && !(rd_en && eff_addr == reg_addr_t'(ADR_IN_BASE)))
    |=> $stable(snap[W-1:0]));
endmodule

bind gpio_chg_irq chg_irq_checker #(.W(PORT_W)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_sync_n),
  .priming  (priming),
  .rd_en    (rd_en_i),
  .eff_addr (eff_addr),
  .ptr      (ptr),
  .sync     (pins_sync),
  .snap     (snap_all),
  .dir      (dir_all),
  .rd_data  (rd_data_o),
  .irq      (irq_pd_o)
);

// File: tb/gpio_chg_irq_bench.sv
`timescale 1ns/1ps
module gpio_chg_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pins;
  logic        rd_start, rd_en, wr_en;
  logic [2:0]  rd_addr, wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_chg_irq u_gpio_chg_irq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pins_i     (pins),
    .rd_start_i (rd_start),
    .rd_addr_i  (rd_addr),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .irq_pd_o   (irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic start, input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_start = start; rd_addr = a;
    step(1);
    rd_en = 1'b0; rd_start = 1'b0;
    d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check({15'd0, irq}, 16'd0, "R1 irq after priming");
    check({8'd0, rd_data}, 16'd0, "R1 rd_data reset");
    rd(1'b1, 3'd2, d); check({8'd0, d}, 16'h00FF, "R1 dir0 reset");
    rd(1'b1, 3'd3, d); check({8'd0, d}, 16'h00FF, "R1 dir1 reset");
    rd(1'b1, 3'd0, d); check({8'd0, d}, {8'd0, pins[7:0]}, "R3 port0 read value");
  endtask

  task automatic t_assert_and_return();
    pins = pins ^ 16'h0008;
    step(1); check({15'd0, irq}, 16'd0, "R2 one edge too early");
    step(1); check({15'd0, irq}, 16'd1, "R2 asserted after sync");
    pins = pins ^ 16'h0008;
    step(2); check({15'd0, irq}, 16'd0, "R4 self release on return");
  endtask

  task automatic t_read_clear();
    logic [7:0] d;
    pins = pins ^ 16'h0041;
    step(2); check({15'd0, irq}, 16'd1, "R2 multi-bit change");
    rd(1'b1, 3'd0, d);
    check({8'd0, d}, {8'd0, pins[7:0]}, "R3 captured byte");
    check({15'd0, irq}, 16'd0, "R3 read clears irq");
  endtask

  task automatic t_change_after_capture();
    logic [7:0] d, old;
    old = pins[7:0];
    rd(1'b1, 3'd0, d);
    pins = pins ^ 16'h0080;
    check({8'd0, d}, {8'd0, old}, "R5 read data keeps old value");
    step(2); check({15'd0, irq}, 16'd1, "R5 late change reasserts");
    rd(1'b1, 3'd0, d);
    check({15'd0, irq}, 16'd0, "R5 cleared by second read");
  endtask

  task automatic t_other_port();
    logic [7:0] d;
    pins = pins ^ 16'h0201;
    step(2);
    rd(1'b1, 3'd0, d);
    check({15'd0, irq}, 16'd1, "R8 port1 mismatch survives port0 read");
    rd(1'b1, 3'd1, d);
    check({8'd0, d}, {8'd0, pins[15:8]}, "R8 port1 byte");
    check({15'd0, irq}, 16'd0, "R8 cleared by port1 read");
  endtask

  task automatic t_autoinc();
    logic [7:0] d0, d1;
    pins = pins ^ 16'h8010;
    step(2);
    rd(1'b1, 3'd0, d0);
    rd(1'b0, 3'd0, d1);
    check({8'd0, d0}, {8'd0, pins[7:0]}, "R7 first phase port0");
    check({8'd0, d1}, {8'd0, pins[15:8]}, "R7 second phase port1");
    check({15'd0, irq}, 16'd0, "R7 both ports refreshed");
  endtask

  task automatic t_direction();
    logic [7:0] d;
    wr(3'd3, 8'h0F);
    wr(3'd0, 8'h00);
    rd(1'b1, 3'd3, d); check({8'd0, d}, 16'h000F, "R6 dir1 readback");
    rd(1'b1, 3'd2, d); check({8'd0, d}, 16'h00FF, "R6 stray write ignored");
    pins = pins ^ 16'h1000;
    step(3); check({15'd0, irq}, 16'd0, "R6 output pin masked");
    pins = pins ^ 16'h0001;
    step(2); check({15'd0, irq}, 16'd1, "R6 port0 still input after stray write");
    rd(1'b1, 3'd0, d);
    pins = pins ^ 16'h0100;
    step(2); check({15'd0, irq}, 16'd1, "R6 input pin of port1 counts");
    rd(1'b1, 3'd1, d);
    check({15'd0, irq}, 16'd0, "R6 cleared");
  endtask

  initial begin
    rst_n = 1'b0; pins = 16'hA55A;
    rd_start = 1'b0; rd_en = 1'b0; rd_addr = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    step(1);
    check({15'd0, irq}, 16'd0, "R1 irq in reset");
    step(3);
    rst_n = 1'b1;
    step(10);
    t_reset();
    t_assert_and_return();
    t_read_clear();
    t_change_after_capture();
    t_other_port();
    t_autoinc();
    t_direction();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule